// File: doc/BRIEF.md
# Region-Based Frequent Writeback Predictor

This block is a small set-associative table placed beside the tag array of a last-level cache in front of a memory whose writes are slow and costly. It learns which memory regions keep coming back as dirty evictions and, on every write access to the cache, returns a one-bit hint. The hint says whether the written line belongs to a region that is written back often and whether that particular line has itself been written back. The replacement logic of the cache can then keep such lines longer. That use of the hint lies outside this block.

Each table entry covers a region of 16 consecutive cache blocks, one block in each of 16 consecutive cache sets. An entry carries a 16-bit partial tag, a 6-bit writeback frequency count, a 3-bit recency rank and one flag bit for each of the 16 cache sets it covers. The update port is driven on every dirty eviction and trains the table. The lookup port is driven on every write access and reads the table only. Entries are replaced by the lowest weighted sum of frequency and recency, not by plain LRU, so a region that was written back often survives a stretch of time without use.

Top module: `wb_region_predictor`

## Requirements
- R1: After reset every entry is invalid, and every lookup answers with lk_frequent = 0.
- R2: lk_rsp_valid is 1 exactly in the cycle after a cycle with lk_valid = 1. In that cycle lk_frequent is 1 only if a valid entry of the addressed predictor set carries the request's partial tag and has its flag bit set at the request's position.
- R3: An update whose partial tag hits a valid entry sets that entry's flag bit at the update's position, keeps all of its other flag bits and raises its frequency count by one.
- R4: An update that misses allocates an entry with frequency count 0 and with only the flag bit at the update's position set, so no flag of the previous occupant survives.
- R5: Address fields of lk_addr and up_addr: bits [3:0] select the flag position, bits [5:4] select the cache-set group, bits [7:6] pick one of the group's 4 predictor sets (predictor set index = {bits[5:4], bits[7:6]}), bits [23:8] form the partial tag, and bits [25:24] are not compared, so addresses that differ only there alias.
- R6: Each predictor set holds 6 entries. Invalid entries are filled, lowest way first, before any valid entry is replaced.
- R7: With no invalid entry, the entry replaced is the one with the smallest F + 4*R (F = frequency count, R = recency rank 0..5, 5 = most recent), the lowest way winning a tie. Every update makes its target entry rank 5 and lowers by one each rank that was above the target's old rank. After reset, way w has rank w.
- R8: The frequency count saturates at 63 and does not wrap.
- R9: When an update and a lookup come in the same cycle, the lookup answer already reflects the update.
- R10: Lookups change no table state: no recency rank, count, flag or tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_valid | input | 1 | Write access to the cache: lookup request |
| lk_addr | input | 26 | Line address of the written cache line |
| up_valid | input | 1 | Dirty eviction from the cache: training request |
| up_addr | input | 26 | Line address of the evicted dirty line |
| lk_rsp_valid | output | 1 | Lookup answer valid, one cycle after lk_valid |
| lk_frequent | output | 1 | Frequent-writeback hint for the looked-up line |

## Verification
The bench goes after the victim-choice corner cases. In the first, a frequently written region holds rank 0 and must outlive a fresh region, which a plain LRU design would evict. In the second, equal weighted scores must fall to the lowest way, and a design that took the last minimum would evict the wrong region. A saturation case drives one region through 70 hits so that a wrapping counter would drop to 6 and lose that region instead of a cheaper neighbour. Further cases cover a reused way that must not keep its old flags, partial-tag aliasing on the uncompared top bits, lookups that must not refresh recency, and an update in the same cycle as a lookup, where a design that answered from the old table would return 0.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  localparam int unsigned DEF_WAYS      = 6;
  localparam int unsigned DEF_PTAG_W    = 16;
  localparam int unsigned DEF_FREQ_W    = 6;
  localparam int unsigned DEF_REC_SHIFT = 2;
  localparam int unsigned DEF_GRP_LOG2  = 4;
  localparam int unsigned DEF_PSEL_W    = 2;

  typedef enum logic {
    UPD_ALLOC = 1'b0,
    UPD_HIT   = 1'b1
  } upd_kind_e;
endpackage

// File: rtl/wbp_tag_match.sv
module wbp_tag_match #(
  parameter int unsigned WAYS   = 6,
  parameter int unsigned PTAG_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic [WAYS-1:0]              way_vld,
  input  logic [WAYS-1:0][PTAG_W-1:0]  way_tag,
  input  logic [PTAG_W-1:0]            req_tag,
  output logic [WAYS-1:0]              hit
);
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      hit[w] = way_vld[w] && (way_tag[w] == req_tag);
    end
  end

  // Allocation happens only on a miss, so one tag never sits twice in a set (R4)
  assert_hit_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $onehot0(hit));
endmodule

// File: rtl/wbp_victim_pick.sv
module wbp_victim_pick #(
  parameter int unsigned WAYS      = 6,
  parameter int unsigned FREQ_W    = 6,
  parameter int unsigned REC_W     = 3,
  parameter int unsigned REC_SHIFT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [WAYS-1:0]             way_vld,
  input  logic [WAYS-1:0][FREQ_W-1:0] way_freq,
  input  logic [WAYS-1:0][REC_W-1:0]  way_rec,
  output logic [REC_W-1:0]            victim
);
  localparam int unsigned SC_W =
    ((FREQ_W > REC_W + REC_SHIFT) ? FREQ_W : REC_W + REC_SHIFT) + 1;

  logic [WAYS-1:0][SC_W-1:0] score;
  logic                      inv_found;
  logic [REC_W-1:0]          inv_way;
  logic [REC_W-1:0]          min_way;
  logic [SC_W-1:0]           min_score;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    min_way   = '0;
    min_score = '1;
    for (int w = 0; w < WAYS; w++) begin
      score[w] = SC_W'(way_freq[w]) + (SC_W'(way_rec[w]) << REC_SHIFT);
      if (!way_vld[w] && !inv_found) begin
        inv_found = 1'b1;
        inv_way   = REC_W'(w);
      end
      if (w == 0 || score[w] < min_score) begin
        min_score = score[w];
        min_way   = REC_W'(w);
      end
    end
    victim = inv_found ? inv_way : min_way;
  end

  // Independent check: no valid way scores below the chosen one, and a lower
  // way with an equal score means the tie was broken wrongly (R7)
  logic bad_pick;
  always_comb begin
    bad_pick = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_vld[w] && score[w] < score[victim]) bad_pick = 1'b1;
      if (way_vld[w] && score[w] == score[victim] && REC_W'(w) < victim) bad_pick = 1'b1;
    end
  end

  assert_victim_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (&way_vld)) |-> !bad_pick);
  assert_victim_invalid_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(&way_vld)) |-> !way_vld[victim]);
endmodule

// File: rtl/wbp_recency_upd.sv
module wbp_recency_upd #(
  parameter int unsigned WAYS  = 6,
  parameter int unsigned REC_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [WAYS-1:0][REC_W-1:0] rec_in,
  input  logic [REC_W-1:0]           touch,
  output logic [WAYS-1:0][REC_W-1:0] rec_out
);
  localparam logic [REC_W-1:0] TOP = REC_W'(WAYS - 1);

  logic [REC_W-1:0] old_rank;
  logic [WAYS-1:0]  at_top;

  always_comb begin
    old_rank = rec_in[touch];
    for (int w = 0; w < WAYS; w++) begin
      if (REC_W'(w) == touch)         rec_out[w] = TOP;
      else if (rec_in[w] > old_rank)  rec_out[w] = rec_in[w] - 1'b1;
      else                            rec_out[w] = rec_in[w];
      at_top[w] = (rec_out[w] == TOP);
    end
  end

  // Exactly one entry is most recent after an update (R7)
  assert_single_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(at_top) == 1));
endmodule

// File: rtl/wb_region_predictor.sv
module wb_region_predictor #(
  parameter int unsigned LINE_ADDR_W = 26,
  parameter int unsigned CSET_W      = 6,
  parameter int unsigned GRP_LOG2    = wbp_pkg::DEF_GRP_LOG2,
  parameter int unsigned PSEL_W      = wbp_pkg::DEF_PSEL_W,
  parameter int unsigned WAYS        = wbp_pkg::DEF_WAYS,
  parameter int unsigned PTAG_W      = wbp_pkg::DEF_PTAG_W,
  parameter int unsigned FREQ_W      = wbp_pkg::DEF_FREQ_W,
  parameter int unsigned REC_SHIFT   = wbp_pkg::DEF_REC_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [LINE_ADDR_W-1:0] lk_addr,
  input  logic                   up_valid,
  input  logic [LINE_ADDR_W-1:0] up_addr,
  output logic                   lk_rsp_valid,
  output logic                   lk_frequent
);
  import wbp_pkg::*;

  localparam int unsigned PSET_W   = CSET_W - GRP_LOG2 + PSEL_W;
  localparam int unsigned PSETS    = 1 << PSET_W;
  localparam int unsigned FLAGS    = 1 << GRP_LOG2;
  localparam int unsigned REC_W    = $clog2(WAYS);
  localparam int unsigned PTAG_LSB = CSET_W + PSEL_W;
  localparam int unsigned HI_LSB   = PTAG_LSB + PTAG_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Table state
  logic              vld_q  [PSETS][WAYS];
  logic [PTAG_W-1:0] tag_q  [PSETS][WAYS];
  logic [FREQ_W-1:0] freq_q [PSETS][WAYS];
  logic [REC_W-1:0]  rec_q  [PSETS][WAYS];
  logic [FLAGS-1:0]  flag_q [PSETS][WAYS];

  // Update path: address split
  logic [PSET_W-1:0]   up_set;
  logic [GRP_LOG2-1:0] up_pos;
  logic [PTAG_W-1:0]   up_ptag;
  logic                up_hi_unused;
  assign up_set       = {up_addr[CSET_W-1:GRP_LOG2], up_addr[PTAG_LSB-1:CSET_W]};
  assign up_pos       = up_addr[GRP_LOG2-1:0];
  assign up_ptag      = up_addr[PTAG_LSB +: PTAG_W];
  assign up_hi_unused = ^up_addr[LINE_ADDR_W-1:HI_LSB];

  logic [WAYS-1:0]             up_vld;
  logic [WAYS-1:0][PTAG_W-1:0] up_tag;
  logic [WAYS-1:0][FREQ_W-1:0] up_freq;
  logic [WAYS-1:0][REC_W-1:0]  up_rec;
  logic [WAYS-1:0][REC_W-1:0]  up_rec_nx;
  logic [WAYS-1:0]             up_hit;
  logic                        up_hit_any;
  logic [REC_W-1:0]            up_hit_way, up_vic_way, up_tgt;
  logic [FREQ_W-1:0]           tgt_freq_nx;
  logic [FLAGS-1:0]            tgt_flag_nx;
  logic [FLAGS-1:0]            pos_bit;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      up_vld[w]  = vld_q[up_set][w];
      up_tag[w]  = tag_q[up_set][w];
      up_freq[w] = freq_q[up_set][w];
      up_rec[w]  = rec_q[up_set][w];
    end
  end

  wbp_tag_match #(.WAYS(WAYS), .PTAG_W(PTAG_W)) u_up_match (
    .clk(clk), .rst_n(rst_sync_n), .en(up_valid),
    .way_vld(up_vld), .way_tag(up_tag), .req_tag(up_ptag), .hit(up_hit));

  wbp_victim_pick #(.WAYS(WAYS), .FREQ_W(FREQ_W), .REC_W(REC_W), .REC_SHIFT(REC_SHIFT)) u_victim (
    .clk(clk), .rst_n(rst_sync_n), .en(up_valid && !up_hit_any),
    .way_vld(up_vld), .way_freq(up_freq), .way_rec(up_rec), .victim(up_vic_way));

  wbp_recency_upd #(.WAYS(WAYS), .REC_W(REC_W)) u_recency (
    .clk(clk), .rst_n(rst_sync_n), .en(up_valid),
    .rec_in(up_rec), .touch(up_tgt), .rec_out(up_rec_nx));

  // Next-state of the target entry
  always_comb begin
    up_hit_any = |up_hit;
    up_hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (up_hit[w]) up_hit_way = REC_W'(w);
    end
    up_tgt  = up_hit_any ? up_hit_way : up_vic_way;
    pos_bit = FLAGS'(1) << up_pos;
    if (up_hit_any) begin
      tgt_freq_nx = (&up_freq[up_tgt]) ? up_freq[up_tgt] : up_freq[up_tgt] + 1'b1;
      tgt_flag_nx = flag_q[up_set][up_tgt] | pos_bit;
    end else begin
      tgt_freq_nx = '0;
      tgt_flag_nx = pos_bit;
    end
  end

  // Table registers, written only by the update port
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int s = 0; s < PSETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w]  <= 1'b0;
          tag_q[s][w]  <= '0;
          freq_q[s][w] <= '0;
          rec_q[s][w]  <= REC_W'(w);
          flag_q[s][w] <= '0;
        end
      end
    end else if (up_valid) begin
      for (int w = 0; w < WAYS; w++) begin
        rec_q[up_set][w] <= up_rec_nx[w];
        if (REC_W'(w) == up_tgt) begin
          vld_q[up_set][w]  <= 1'b1;
          tag_q[up_set][w]  <= up_ptag;
          freq_q[up_set][w] <= tgt_freq_nx;
          flag_q[up_set][w] <= tgt_flag_nx;
        end
      end
    end
  end

  // Lookup path: request registered, answered from the table after the
  // same edge has committed any concurrent update
  logic                   lk_q_valid;
  logic [LINE_ADDR_W-1:0] lk_q_addr;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) lk_q_valid <= 1'b0;
    else             lk_q_valid <= lk_valid;
  end

  always_ff @(posedge clk) begin
    if (lk_valid) lk_q_addr <= lk_addr;
  end

  logic [PSET_W-1:0]           lk_set;
  logic [GRP_LOG2-1:0]         lk_pos;
  logic [PTAG_W-1:0]           lk_ptag;
  logic                        lk_hi_unused;
  logic [WAYS-1:0]             lk_vld, lk_hit, lk_bit;
  logic [WAYS-1:0][PTAG_W-1:0] lk_tag;

  assign lk_set       = {lk_q_addr[CSET_W-1:GRP_LOG2], lk_q_addr[PTAG_LSB-1:CSET_W]};
  assign lk_pos       = lk_q_addr[GRP_LOG2-1:0];
  assign lk_ptag      = lk_q_addr[PTAG_LSB +: PTAG_W];
  assign lk_hi_unused = ^lk_q_addr[LINE_ADDR_W-1:HI_LSB];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_vld[w] = vld_q[lk_set][w];
      lk_tag[w] = tag_q[lk_set][w];
      lk_bit[w] = flag_q[lk_set][w][lk_pos];
    end
  end

  wbp_tag_match #(.WAYS(WAYS), .PTAG_W(PTAG_W)) u_lk_match (
    .clk(clk), .rst_n(rst_sync_n), .en(lk_q_valid),
    .way_vld(lk_vld), .way_tag(lk_tag), .req_tag(lk_ptag), .hit(lk_hit));

  assign lk_rsp_valid = lk_q_valid;
  assign lk_frequent  = lk_q_valid && |(lk_hit & lk_bit);

  // Shadow of the last update, kept for the checks below
  logic              chk_v;
  upd_kind_e         chk_kind;
  logic [PSET_W-1:0] chk_set;
  logic [REC_W-1:0]  chk_way;
  logic [GRP_LOG2-1:0] chk_pos;
  logic [FREQ_W-1:0] chk_fexp;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chk_v <= 1'b0;
    else             chk_v <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (up_valid) begin
      chk_kind <= up_hit_any ? UPD_HIT : UPD_ALLOC;
      chk_set  <= up_set;
      chk_way  <= up_tgt;
      chk_pos  <= up_pos;
      chk_fexp <= (up_freq[up_tgt] == {FREQ_W{1'b1}}) ? up_freq[up_tgt]
                                                     : up_freq[up_tgt] + 1'b1;
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_valid |=> lk_rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_valid |=> !lk_rsp_valid);
  assert_flag_marked_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_v |-> (vld_q[chk_set][chk_way] && flag_q[chk_set][chk_way][chk_pos]));
  assert_alloc_clean_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_v && chk_kind == UPD_ALLOC) |->
      (freq_q[chk_set][chk_way] == '0 && $onehot(flag_q[chk_set][chk_way])));
  assert_freq_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_v && chk_kind == UPD_HIT) |-> (freq_q[chk_set][chk_way] == chk_fexp));
  assert_target_mru_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_v |-> (rec_q[chk_set][chk_way] == REC_W'(WAYS - 1)));
endmodule

// File: tb/wb_region_predictor_test.sv
module wb_region_predictor_test;
  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_valid, up_valid;
  logic [AW-1:0] lk_addr, up_addr;
  logic          lk_rsp_valid, lk_frequent;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wb_region_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .up_valid(up_valid), .up_addr(up_addr),
    .lk_rsp_valid(lk_rsp_valid), .lk_frequent(lk_frequent));

  // Address: {uncompared[1:0], partial tag[15:0], set select[1:0], group[1:0], position[3:0]}
  function automatic logic [AW-1:0] ad(input logic [1:0] hi, input logic [15:0] pt,
                                       input logic [1:0] sel, input logic [1:0] grp,
                                       input logic [3:0] pos);
    return {hi, pt, sel, grp, pos};
  endfunction

  // Vector: {kind[1:0] (0 = update, 1 = lookup and check), req[3:0], addr[25:0], expected}
  localparam int NV = 11;
  localparam logic [32:0] VEC [NV] = '{
    {2'd1, 4'd1, 2'd0, 16'h0011, 2'd0, 2'd0, 4'd3, 1'b0},  // R1 empty table
    {2'd0, 4'd4, 2'd0, 16'h0011, 2'd0, 2'd0, 4'd3, 1'b0},  // allocate
    {2'd1, 4'd2, 2'd0, 16'h0011, 2'd0, 2'd0, 4'd3, 1'b1},  // R2 hit with flag
    {2'd1, 4'd3, 2'd0, 16'h0011, 2'd0, 2'd0, 4'd4, 1'b0},  // R3 same region, flag clear
    {2'd0, 4'd3, 2'd0, 16'h0011, 2'd0, 2'd0, 4'd4, 1'b0},  // hit update at pos 4
    {2'd1, 4'd3, 2'd0, 16'h0011, 2'd0, 2'd0, 4'd4, 1'b1},  // R3 new flag
    {2'd1, 4'd3, 2'd0, 16'h0011, 2'd0, 2'd0, 4'd3, 1'b1},  // R3 old flag kept
    {2'd1, 4'd5, 2'd3, 16'h0011, 2'd0, 2'd0, 4'd3, 1'b1},  // R5 top bits alias
    {2'd1, 4'd5, 2'd0, 16'h0011, 2'd1, 2'd0, 4'd3, 1'b0},  // R5 other set select
    {2'd1, 4'd5, 2'd0, 16'h0011, 2'd0, 2'd1, 4'd3, 1'b0},  // R5 other group
    {2'd1, 4'd5, 2'd0, 16'h0012, 2'd0, 2'd0, 4'd3, 1'b0}   // R5 other partial tag
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n    = 1'b0;
    lk_valid = 1'b0;
    up_valid = 1'b0;
    lk_addr  = '0;
    up_addr  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic upd(input logic [AW-1:0] a);
    up_valid = 1'b1;
    up_addr  = a;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] a, input logic exp, input string req);
    lk_valid = 1'b1;
    lk_addr  = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, "rsp_valid", lk_rsp_valid, 1'b1);
    check(req, $sformatf("frequent @%h", a), lk_frequent, exp);
  endtask

  task automatic both(input logic [AW-1:0] ua, input logic [AW-1:0] la, input logic exp);
    up_valid = 1'b1;
    up_addr  = ua;
    lk_valid = 1'b1;
    lk_addr  = la;
    @(negedge clk);
    up_valid = 1'b0;
    lk_valid = 1'b0;
    check("R9", "frequent same cycle", lk_frequent, exp);
  endtask

  // Regions t = 1..7 in group 1, set select 2
  function automatic logic [AW-1:0] rg(input int t, input logic [3:0] pos);
    return ad(2'd0, 16'(t), 2'd2, 2'd1, pos);
  endfunction

  initial begin
    apply_reset();
    check("R1", "rsp_valid idle", lk_rsp_valid, 1'b0);
    check("R1", "frequent idle", lk_frequent, 1'b0);

    // Table walk: basic lookup, flags, address fields
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32:31] == 2'd0) upd(VEC[i][26:1]);
      else look(VEC[i][26:1], VEC[i][0], $sformatf("R%0d", VEC[i][30:27]));
    end

    // R6, R10: fill six ways, lookups must not refresh recency, then R7 evicts LRU
    apply_reset();
    for (int t = 1; t <= 6; t++) upd(rg(t, 4'd0));
    for (int t = 1; t <= 6; t++) look(rg(t, 4'd0), 1'b1, "R6");
    for (int k = 0; k < 5; k++) look(rg(1, 4'd0), 1'b1, "R10");
    upd(rg(7, 4'd0));
    look(rg(1, 4'd0), 1'b0, "R10");
    look(rg(7, 4'd0), 1'b1, "R7");
    look(rg(2, 4'd0), 1'b1, "R7");
    // R4: region 1 lands in the way that held region 2 (flag at pos 0)
    upd(rg(1, 4'd9));
    look(rg(1, 4'd9), 1'b1, "R4");
    look(rg(1, 4'd0), 1'b0, "R4");
    look(rg(2, 4'd0), 1'b0, "R4");

    // R7 weighted: region 1 with count 9 at rank 0 outlives region 2 (score 4)
    apply_reset();
    upd(rg(1, 4'd0));
    for (int k = 0; k < 9; k++) upd(rg(1, 4'd0));
    for (int t = 2; t <= 6; t++) upd(rg(t, 4'd0));
    upd(rg(7, 4'd0));
    look(rg(1, 4'd0), 1'b1, "R7");
    look(rg(2, 4'd0), 1'b0, "R7");
    look(rg(7, 4'd0), 1'b1, "R7");

    // R7 tie: region 1 score 4+0, region 2 score 0+4, lowest way loses
    apply_reset();
    upd(rg(1, 4'd0));
    for (int k = 0; k < 4; k++) upd(rg(1, 4'd0));
    for (int t = 2; t <= 6; t++) upd(rg(t, 4'd0));
    upd(rg(7, 4'd0));
    look(rg(1, 4'd0), 1'b0, "R7");
    look(rg(2, 4'd0), 1'b1, "R7");

    // R8: 70 hits saturate at 63; a wrap to 6 would make region 1 the victim
    apply_reset();
    upd(rg(1, 4'd0));
    for (int k = 0; k < 70; k++) upd(rg(1, 4'd0));
    upd(rg(2, 4'd0));
    for (int k = 0; k < 10; k++) upd(rg(2, 4'd0));
    for (int t = 3; t <= 6; t++) upd(rg(t, 4'd0));
    upd(rg(7, 4'd0));
    look(rg(1, 4'd0), 1'b1, "R8");
    look(rg(3, 4'd0), 1'b0, "R8");
    look(rg(7, 4'd0), 1'b1, "R8");
    look(rg(2, 4'd0), 1'b1, "R8");

    // R9: update and lookup of the same set in one cycle
    apply_reset();
    both(rg(5, 4'd5), rg(5, 4'd5), 1'b1);
    both(rg(5, 4'd6), rg(5, 4'd6), 1'b1);
    look(rg(5, 4'd7), 1'b0, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule